// File: doc/BRIEF.md
# Sparse On-Demand Paged Memory

This block presents a wide byte-addressed window while holding real storage for only a few page frames. The address is split into a page number and an offset within the page. A small fully associative tag table records which pages own a frame. A page gets a frame only when a write with nonzero data reaches it while it has none. Reads of pages that own no frame return zero. Writes that cannot be given a frame are thrown away without any effect.

Requests arrive on a single-cycle synchronous interface. Each request carries an address, a write flag, a byte count of 1, 2, 4 or 8, and 64-bit write data. One cycle later the block answers with a response strobe, an error flag and read data. Data is little-endian: the byte at the lowest address sits in the least significant lane. A frame count output shows how many frames are claimed. Claimed frames are never given back except by reset.

A frame is claimed only while two limits hold. The bytes already backed plus one more page must stay strictly below a byte budget. A free tag entry must also be available.

Top module: `sparse_paged_mem`

## Requirements
- R1: Every request produces `rsp_valid` high in the cycle after it; read data and error belong to that request.
- R2: Page number is address divided by `PAGE_BYTES`, offset is the remainder; distinct backed pages hold independent data.
- R3: A read of a page with no frame returns zero and claims no frame.
- R4: A write whose data, restricted to its low `req_size` bytes, is zero does not claim a frame for an unbacked page; that page still reads zero.
- R5: A frame is claimed only if (frames_used + 1) * `PAGE_BYTES` < `MAX_BYTES`; otherwise the write is dropped and the page stays unbacked.
- R6: A frame is claimed only if a tag entry is free; with all `NUM_FRAMES` entries in use, writes to new pages are dropped.
- R7: A newly claimed frame reads zero in every byte not written by the claiming write.
- R8: `req_size` must be 1, 2, 4 or 8 and the address a multiple of it; otherwise `rsp_err` is 1, `rsp_rdata` is 0 and nothing changes.
- R9: Byte k of the data (bits 8k+7:8k) maps to address addr+k; reads return the accessed bytes zero-extended in the low lanes.
- R10: A write of zero data to a page that already has a frame updates the bytes normally.
- R11: After reset `frames_used` is 0 and every page reads zero.
- R12: `frames_used` equals the number of frames claimed since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Access size in bytes (1, 2, 4, 8 legal) |
| req_wdata | input | 64 | Write data, low lanes used |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_err | output | 1 | Illegal size or misaligned request |
| rsp_rdata | output | 64 | Read data, zero-extended |
| frames_used | output | CNT_W | Number of claimed frames |

## Verification
The bench sweeps every offset of a word with every size, legal and illegal. This separates lane placement and zero extension from the alignment rule. Probe writes use nonzero and zero data and land on both fresh and backed pages. This separates the claiming rule from the ordinary update path. A run of writes to new pages is sent to two configurations at once. One is limited by its byte budget and the other by its tag table, so each limit is seen on its own. The bench holds an arithmetic byte-level model and compares every response and frame count against it.

// File: rtl/sparse_pkg.sv
// Shared definitions for the sparse paged memory.
// Assumes a 64-bit data path and byte addressing.
package sparse_pkg;
    localparam int WORD_BYTES = 8;
    typedef logic [63:0] word_t;

    // True for the four supported access sizes.
    function automatic logic size_supported(input logic [3:0] sz);
        return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
    endfunction
endpackage

// File: rtl/sparse_access_decode.sv
// Decodes size and low address bits into legality, byte lanes and a data mask.
// Assumes an access never spans more than one 64-bit word once it is aligned.
module sparse_access_decode
    import sparse_pkg::*;
(
    input  logic [2:0] addr_lo,
    input  logic [3:0] size,
    output logic       legal,
    output logic [7:0] lane_en,
    output word_t      data_mask
);
    logic aligned;

    // Alignment of the address to its own size.
    always_comb begin
        case (size)
            4'd2:    aligned = (addr_lo[0] == 1'b0);
            4'd4:    aligned = (addr_lo[1:0] == 2'b00);
            4'd8:    aligned = (addr_lo == 3'b000);
            default: aligned = 1'b1;
        endcase
        legal = size_supported(size) && aligned;
    end

    // Low-lane mask for data and the lanes the access touches in the word.
    always_comb begin
        for (int k = 0; k < WORD_BYTES; k++) begin
            data_mask[8*k +: 8] = (k < int'(size)) ? 8'hFF : 8'h00;
            lane_en[k] = legal && (k >= int'(addr_lo)) && (k < int'(addr_lo) + int'(size));
        end
    end
endmodule

// File: rtl/sparse_tag_table.sv
// Fully associative page-to-frame table with on-demand claiming.
// Assumes lookups are combinational and a claim commits at the clock edge.
// Entries are only released by reset.
module sparse_tag_table #(
    parameter int PAGE_W     = 4,
    parameter int NUM_FRAMES = 4,
    parameter int PAGE_BYTES = 4096,
    parameter int MAX_BYTES  = 20000,
    localparam int FIDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int CNT_W  = $clog2(NUM_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] page,
    input  logic              alloc_req,
    output logic              hit,
    output logic [FIDX_W-1:0] hit_idx,
    output logic [FIDX_W-1:0] free_idx,
    output logic              alloc_go,
    output logic [CNT_W-1:0]  count
);
    logic [NUM_FRAMES-1:0] valid;
    logic [PAGE_W-1:0]     tag [NUM_FRAMES];
    logic [NUM_FRAMES-1:0] hitvec;
    logic                  any_free;
    logic                  cap_ok;

    // Parallel compare of every entry against the request page.
    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_cmp
        assign hitvec[i] = valid[i] && (tag[i] == page);
    end

    // Encode the hit entry and pick the lowest free entry.
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        any_free = 1'b0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (hitvec[i]) hit_idx = FIDX_W'(i);
            if (!valid[i]) begin
                free_idx = FIDX_W'(i);
                any_free = 1'b1;
            end
        end
        hit = |hitvec;
    end

    // Byte budget test and final claim decision.
    always_comb begin
        cap_ok   = ((64'(count) + 64'd1) * 64'(PAGE_BYTES)) < 64'(MAX_BYTES);
        alloc_go = alloc_req && !hit && any_free && cap_ok;
    end

    // Entry state and claimed-frame counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            count <= '0;
            for (int i = 0; i < NUM_FRAMES; i++) tag[i] <= '0;
        end else if (alloc_go) begin
            valid[free_idx] <= 1'b1;
            tag[free_idx]   <= page;
            count           <= count + CNT_W'(1);
        end
    end

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hitvec)); // R2
    AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (64'(count) * 64'(PAGE_BYTES)) < 64'(MAX_BYTES) || count == '0); // R5
    AST_NO_CLAIM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_req |=> $stable(count)); // R4
    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        32'($countones(valid)) == 32'(count)); // R12
endmodule

// File: rtl/sparse_frame_store.sv
// Word storage for all frames with a touched bit per word.
// A word never written since its frame was claimed reads as zero,
// which makes claiming a frame a single-cycle clear of its touched bits.
module sparse_frame_store
    import sparse_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter int WPP        = 512,
    localparam int FIDX_W  = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int WORD_W  = (WPP > 1) ? $clog2(WPP) : 1,
    localparam int NWORDS  = NUM_FRAMES * WPP,
    localparam int WIDX_W  = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FIDX_W-1:0] frame,
    input  logic [WORD_W-1:0] word,
    input  logic              wr_en,
    input  logic              clr_en,
    input  logic [7:0]        lane_en,
    input  word_t             wdata,
    output word_t             rd_word
);
    word_t              mem [NWORDS];
    logic [NWORDS-1:0]  touched;
    logic [WIDX_W-1:0]  widx;
    word_t              base;

    // Flat word index and the old contents seen by a merge.
    always_comb begin
        widx    = WIDX_W'(int'(frame) * WPP + int'(word));
        rd_word = touched[widx] ? mem[widx] : '0;
        base    = (touched[widx] && !clr_en) ? mem[widx] : '0;
    end

    // Touched bits: cleared frame-wide on a claim, set on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            touched <= '0;
        end else begin
            if (clr_en) begin
                for (int i = 0; i < NWORDS; i++)
                    if ((i / WPP) == int'(frame)) touched[i] <= 1'b0;
            end
            if (wr_en) touched[widx] <= 1'b1;
        end
    end

    // Byte-lane merge of write data into the addressed word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < WORD_BYTES; k++)
                mem[widx][8*k +: 8] <= lane_en[k] ? wdata[8*k +: 8] : base[8*k +: 8];
        end
    end
endmodule

// File: rtl/sparse_paged_mem.sv
// Sparse memory top: splits the address, looks up the page, claims a
// frame on the first nonzero write and returns read data one cycle later.
// Assumes PAGE_BYTES is a power of two, at least 16.
module sparse_paged_mem
    import sparse_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int NUM_FRAMES = 4,
    parameter int MAX_BYTES  = 20000,
    localparam int CNT_W = $clog2(NUM_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    output logic [CNT_W-1:0]  frames_used
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int WPP    = PAGE_BYTES / WORD_BYTES;
    localparam int WORD_W = OFF_W - 3;
    localparam int FIDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;

    logic [PAGE_W-1:0] page;
    logic [WORD_W-1:0] word;
    logic [2:0]        boff;
    logic              legal;
    logic [7:0]        lane_en;
    word_t             data_mask;
    logic              alloc_req, alloc_go, hit, do_write;
    logic [FIDX_W-1:0] hit_idx, free_idx, frame;
    word_t             wdata_pos, rd_word, rd_val;

    // Address split into page, word within page and byte within word.
    always_comb begin
        page = req_addr[ADDR_W-1:OFF_W];
        word = req_addr[OFF_W-1:3];
        boff = req_addr[2:0];
    end

    sparse_access_decode u_dec (
        .addr_lo   (boff),
        .size      (req_size),
        .legal     (legal),
        .lane_en   (lane_en),
        .data_mask (data_mask)
    );

    // Claim request, target frame and data positioned on its lanes.
    always_comb begin
        alloc_req = req_valid && req_write && legal && ((req_wdata & data_mask) != '0);
        do_write  = req_valid && req_write && legal && (hit || alloc_go);
        frame     = hit ? hit_idx : free_idx;
        wdata_pos = (req_wdata & data_mask) << {boff, 3'b000};
        rd_val    = (rd_word >> {boff, 3'b000}) & data_mask;
    end

    sparse_tag_table #(
        .PAGE_W     (PAGE_W),
        .NUM_FRAMES (NUM_FRAMES),
        .PAGE_BYTES (PAGE_BYTES),
        .MAX_BYTES  (MAX_BYTES)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .page      (page),
        .alloc_req (alloc_req),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .free_idx  (free_idx),
        .alloc_go  (alloc_go),
        .count     (frames_used)
    );

    sparse_frame_store #(
        .NUM_FRAMES (NUM_FRAMES),
        .WPP        (WPP)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame   (frame),
        .word    (word),
        .wr_en   (do_write),
        .clr_en  (alloc_go),
        .lane_en (lane_en),
        .wdata   (wdata_pos),
        .rd_word (rd_word)
    );

    // Registered response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !legal;
            rsp_rdata <= (req_valid && !req_write && legal && hit) ? rd_val : '0;
        end
    end

    AST_UNBACKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && !hit |=> rsp_rdata == '0); // R3
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !legal |=> $stable(frames_used)); // R8
    AST_READ_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> $stable(frames_used)); // R3
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid)); // R1
endmodule

// File: tb/sparse_paged_mem_test.sv
// Bench: two small configurations driven with the same requests and
// compared with a byte-level arithmetic model.
module sparse_paged_mem_test;
    localparam int P = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        v0, e0, v1, e1;
    logic [63:0] d0, d1;
    logic [2:0]  f0;
    logic [1:0]  f1;

    int checks = 0, errors = 0;
    bit finished = 0;

    // Model state: [0] budget-limited instance, [1] table-limited instance.
    byte unsigned mem [2][65536];
    bit           back [2][1024];
    int           used [2];
    int           flim [2] = '{4, 2};
    int           mlim [2] = '{200, 1000};

    always #2 clk = ~clk;

    sparse_paged_mem #(.ADDR_W(16), .PAGE_BYTES(P), .NUM_FRAMES(4), .MAX_BYTES(200)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(v0), .rsp_err(e0), .rsp_rdata(d0), .frames_used(f0));

    sparse_paged_mem #(.ADDR_W(16), .PAGE_BYTES(P), .NUM_FRAMES(2), .MAX_BYTES(1000)) uut_small (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(v1), .rsp_err(e1), .rsp_rdata(d1), .frames_used(f1));

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            used[k] = 0;
            for (int p = 0; p < 1024; p++) back[k][p] = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk(f0 == 0, "R11", "frames_used after reset", 64'(f0), 0);
        chk(f1 == 0, "R11", "small frames_used after reset", 64'(f1), 0);
        chk(v0 == 0, "R11", "rsp_valid after reset", 64'(v0), 0);
    endtask

    // One request; both instances compared with the model afterwards.
    task automatic op(input bit we, input int addr, input int sz,
                      input logic [63:0] d, input string rq);
        logic [63:0] erd [2];
        bit          eerr;
        logic [63:0] ard [2];
        bit          aerr [2];
        bit          aval [2];
        int          afr [2];
        int          pg;
        bit          lg, nz;
        req_valid = 1'b1; req_write = we; req_addr = 16'(addr);
        req_size = 4'(sz); req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        ard[0] = d0; aerr[0] = e0; aval[0] = v0; afr[0] = int'(f0);
        ard[1] = d1; aerr[1] = e1; aval[1] = v1; afr[1] = int'(f1);
        pg = addr / P;
        lg = (sz == 1 || sz == 2 || sz == 4 || sz == 8) && (addr % sz == 0);
        eerr = !lg;
        nz = 0;
        if (lg) for (int b = 0; b < sz; b++) if (d[8*b +: 8] != 0) nz = 1;
        for (int k = 0; k < 2; k++) begin
            erd[k] = '0;
            if (lg && !we && back[k][pg])
                for (int b = 0; b < sz; b++) erd[k][8*b +: 8] = mem[k][addr + b];
            if (lg && we) begin
                if (!back[k][pg] && nz && (used[k] + 1) * P < mlim[k] && used[k] < flim[k]) begin
                    back[k][pg] = 1;
                    used[k]++;
                    for (int b = 0; b < P; b++) mem[k][pg * P + b] = 8'h00;
                end
                if (back[k][pg])
                    for (int b = 0; b < sz; b++) mem[k][addr + b] = d[8*b +: 8];
            end
            chk(aval[k] == 1, "R1", "rsp_valid", 64'(aval[k]), 1);
            chk(aerr[k] == eerr, rq, "rsp_err", 64'(aerr[k]), 64'(eerr));
            chk(ard[k] == erd[k], rq, "rsp_rdata", ard[k], erd[k]);
            chk(afr[k] == used[k], "R12", "frames_used", 64'(afr[k]), 64'(used[k]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R3: reads of unbacked pages return zero and claim nothing.
        for (int p = 0; p < 8; p++) op(0, p * P + 8, 8, 0, "R3");
        // R4: zero write to an unbacked page does not claim a frame.
        op(1, P + 16, 8, 64'h0, "R4");
        op(1, P + 16, 2, 64'hFFFF_0000, "R4");
        op(0, P + 16, 8, 0, "R4");
        // R7: first nonzero byte claims a frame; other bytes read zero.
        op(1, P + 5, 1, 64'hA5, "R7");
        for (int w = 0; w < P / 8; w++) op(0, P + w * 8, 8, 0, "R7");
        // R9 and R8: every size at every offset in one word.
        for (int sz = 0; sz <= 8; sz++)
            for (int off = 0; off < 8; off++) begin
                op(1, P + 24 + off, sz, 64'h0F1E2D3C4B5A6978 ^ 64'(sz * 8 + off), "R9");
                op(0, P + 24, 8, 0, "R9");
                op(0, P + 24 + off, sz, 0, "R8");
            end
        // R8: illegal nonzero write to a fresh page claims nothing.
        op(1, 2 * P + 1, 2, 64'h1234, "R8");
        op(1, 2 * P, 3, 64'h1234, "R8");
        // R2: two more pages; distinct data per page.
        op(1, 2 * P + 8, 8, 64'h2222_3333_4444_5555, "R2");
        op(1, 3 * P + 8, 8, 64'h6666_7777_8888_9999, "R6");
        op(0, P + 8, 8, 0, "R2");
        op(0, 2 * P + 8, 8, 0, "R2");
        op(0, 3 * P + 8, 8, 0, "R6");
        // R5: budget reached in the wide instance; R6 table full in the small one.
        op(1, 4 * P, 4, 64'hDEAD_BEEF, "R5");
        op(0, 4 * P, 4, 0, "R5");
        op(1, 900 * P + 8, 8, 64'h1, "R5");
        op(0, 900 * P + 8, 8, 0, "R5");
        // R10: zero data on a backed page updates normally.
        op(1, 2 * P + 8, 8, 64'h0, "R10");
        op(0, 2 * P + 8, 8, 0, "R10");
        op(1, P + 24, 4, 64'h0, "R10");
        op(0, P + 24, 8, 0, "R10");
        // R11: reset clears everything.
        do_reset();
        op(0, P + 8, 8, 0, "R11");
        op(0, 2 * P + 8, 8, 0, "R11");
        op(1, 5 * P + 2, 2, 64'hBEEF, "R12");
        op(0, 5 * P, 8, 0, "R9");
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule